// File: doc/BRIEF.md
# UART Receive Idle-Gap Packetizer

This block sits between an asynchronous serial input and a downstream network transmitter. It recovers 8N1 characters from the line and stages them in a small character FIFO. From there they move into a circular byte buffer. The block groups the stored bytes into packets by timing alone: a packet closes once the line has been silent for a configured idle interval after the last good character. No delimiter or length field is involved. The downstream side then receives whole messages on a valid/ready byte stream, with the final byte of each packet flagged.

The clock frequency, baud rate and idle interval are parameters. The oversampling divider and the idle cycle count are derived from them at elaboration. The defaults give 9600 bit/s and a 16 ms gap at 50 MHz. Characters that arrive while a packet is still being emptied are held for the next packet. A character with a bad stop bit is discarded and sets a framing flag. A character that finds both storage stages full is discarded and sets an overflow flag.

Top module: `pkt_uart_gap`

## Requirements
- R1: Characters framed as one low start bit, eight data bits least significant first and one high stop bit are delivered on m_data_o in arrival order.
- R2: A character whose stop bit samples low is discarded, and frame_err_o goes high and stays high until reset.
- R3: The circular buffer holds 256 bytes and the FIFO ahead of it 16. A character that arrives while both are full is discarded, and overflow_o goes high and stays high until reset. The stored bytes are unaffected.
- R4: A packet is offered only after IDLE_US microseconds pass with no new good character. Characters spaced more closely than that belong to one packet.
- R5: m_last_o is high on the final byte of each packet and on no other byte.
- R6: Characters received while a packet is being output are not added to it. They form the following packet.
- R7: While m_valid_o is high and m_ready_i is low, m_valid_o, m_data_o and m_last_o hold their values.
- R8: After reset, m_valid_o, busy_o, frame_err_o and overflow_o are low.
- R9: busy_o is high while a packet is being output.
- R10: A low pulse shorter than half a bit period on rx_i produces no character and no framing error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial receive line, idle high |
| m_data_o | output | 8 | Stream byte |
| m_valid_o | output | 1 | Stream byte valid |
| m_last_o | output | 1 | Final byte of packet |
| m_ready_i | input | 1 | Downstream accepts byte |
| busy_o | output | 1 | Packet output in progress |
| frame_err_o | output | 1 | Sticky framing error |
| overflow_o | output | 1 | Sticky overflow |

## Verification
Several kinds of internal fault show up at the stream outputs. A wrong bit counter or sample phase in the receiver corrupts the first byte of the next packet, one idle interval after it arrives. A wrong buffer count or a stale read pointer makes the last marker land on the wrong byte, or makes bytes that arrived during a drain leak into it. A mis-loaded idle timer changes when valid rises relative to the last character, and that is checked against windows on either side of the gap. The overflow case fills both stages completely, so an off-by-one in either depth shows on the flag and in the length of the two packets that follow.

// File: rtl/pkt_pkg.sv
package pkt_pkg;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_BREAK
  } rx_state_e;

  localparam int OVERSAMPLE = 16;

  function automatic int calc_tick_div(int clk_hz, int baud);
    int d;
    d = clk_hz / (baud * OVERSAMPLE);
    return (d < 1) ? 1 : d;
  endfunction

  function automatic int calc_idle_cyc(int clk_hz, int idle_us);
    int c;
    c = (clk_hz / 1_000_000) * idle_us;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/pkt_uart_rx.sv
module pkt_uart_rx #(
  parameter int TICK_DIV = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_i,
  output logic [7:0] byte_o,
  output logic       vld_o,
  output logic       ferr_o
);
  import pkt_pkg::*;

  localparam int DW = $clog2(TICK_DIV + 1);

  logic [1:0]    sync_q;
  logic          rxs;
  logic [DW-1:0] div_q;
  logic          tick;
  rx_state_e     state_q;
  logic [3:0]    os_q;
  logic [2:0]    bit_q;
  logic [7:0]    sh_q;

  assign rxs    = sync_q[1];
  assign tick   = (div_q == DW'(TICK_DIV - 1));
  assign byte_o = sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11;
      div_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], rx_i};
      div_q  <= tick ? '0 : div_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      os_q    <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      vld_o   <= 1'b0;
      ferr_o  <= 1'b0;
    end else begin
      vld_o  <= 1'b0;
      ferr_o <= 1'b0;
      case (state_q)
        RX_IDLE: if (tick && !rxs) begin
          state_q <= RX_START;
          os_q    <= '0;
        end
        RX_START: if (tick) begin
          if (os_q == 4'd7) begin
            // mid start bit: a short glitch is already gone
            state_q <= rxs ? RX_IDLE : RX_DATA;
            os_q    <= '0;
            bit_q   <= '0;
          end else begin
            os_q <= os_q + 1'b1;
          end
        end
        RX_DATA: if (tick) begin
          if (os_q == 4'd15) begin
            os_q <= '0;
            sh_q <= {rxs, sh_q[7:1]};
            if (bit_q == 3'd7) state_q <= RX_STOP;
            else               bit_q   <= bit_q + 1'b1;
          end else begin
            os_q <= os_q + 1'b1;
          end
        end
        RX_STOP: if (tick) begin
          if (os_q == 4'd15) begin
            os_q <= '0;
            if (rxs) begin
              vld_o   <= 1'b1;
              state_q <= RX_IDLE;
            end else begin
              ferr_o  <= 1'b1;
              state_q <= RX_BREAK;
            end
          end else begin
            os_q <= os_q + 1'b1;
          end
        end
        RX_BREAK: if (rxs) state_q <= RX_IDLE;
        default:  state_q <= RX_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pkt_ring.sv
module pkt_ring #(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [7:0]    din_i,
  input  logic          pop_i,
  output logic [7:0]    dout_o,
  output logic [CW-1:0] count_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q;

  function automatic logic [AW-1:0] nxt(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign dout_o = mem[rd_q];

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q    <= '0;
      rd_q    <= '0;
      count_o <= '0;
    end else begin
      if (push_i) wr_q <= nxt(wr_q);
      if (pop_i)  rd_q <= nxt(rd_q);
      case ({push_i, pop_i})
        2'b10:   count_o <= count_o + 1'b1;
        2'b01:   count_o <= count_o - 1'b1;
        default: count_o <= count_o;
      endcase
    end
  end

endmodule

// File: rtl/pkt_idle_tmr.sv
module pkt_idle_tmr #(
  parameter int LIMIT = 800_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic quiet_o
);
  localparam int TW = $clog2(LIMIT + 1);

  logic          armed_q;
  logic [TW-1:0] cnt_q;

  assign quiet_o = !armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (restart_i) begin
      armed_q <= 1'b1;
      cnt_q   <= '0;
    end else if (armed_q) begin
      if (cnt_q == TW'(LIMIT - 1)) armed_q <= 1'b0;
      else                         cnt_q   <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/pkt_uart_gap.sv
module pkt_uart_gap #(
  parameter int CLK_FREQ_HZ = 50_000_000,
  parameter int BAUD        = 9600,
  parameter int IDLE_US     = 16_000,
  parameter int FIFO_DEPTH  = 16,
  parameter int BUF_DEPTH   = 256
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_i,
  output logic [7:0] m_data_o,
  output logic       m_valid_o,
  output logic       m_last_o,
  input  logic       m_ready_i,
  output logic       busy_o,
  output logic       frame_err_o,
  output logic       overflow_o
);
  import pkt_pkg::*;

  localparam int TICK_DIV = calc_tick_div(CLK_FREQ_HZ, BAUD);
  localparam int IDLE_CYC = calc_idle_cyc(CLK_FREQ_HZ, IDLE_US);
  localparam int FCW      = $clog2(FIFO_DEPTH + 1);
  localparam int BCW      = $clog2(BUF_DEPTH + 1);

  logic [7:0]     rx_byte;
  logic           rx_vld, rx_ferr;
  logic [7:0]     fifo_dout;
  logic [FCW-1:0] fifo_cnt;
  logic [BCW-1:0] buf_cnt;
  logic           fifo_full, fifo_empty, buf_full;
  logic           fifo_push, xfer, buf_pop;
  logic           quiet;
  logic           drain_q;
  logic [BCW-1:0] remain_q;
  logic           start;

  pkt_uart_rx #(.TICK_DIV(TICK_DIV)) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rx_i   (rx_i),
    .byte_o (rx_byte),
    .vld_o  (rx_vld),
    .ferr_o (rx_ferr)
  );

  assign fifo_full  = (fifo_cnt == FCW'(FIFO_DEPTH));
  assign fifo_empty = (fifo_cnt == '0);
  assign buf_full   = (buf_cnt == BCW'(BUF_DEPTH));
  assign fifo_push  = rx_vld && !fifo_full;
  assign xfer       = !fifo_empty && !buf_full;

  pkt_ring #(.DEPTH(FIFO_DEPTH), .CW(FCW)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (fifo_push),
    .din_i   (rx_byte),
    .pop_i   (xfer),
    .dout_o  (fifo_dout),
    .count_o (fifo_cnt)
  );

  pkt_ring #(.DEPTH(BUF_DEPTH), .CW(BCW)) u_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (xfer),
    .din_i   (fifo_dout),
    .pop_i   (buf_pop),
    .dout_o  (m_data_o),
    .count_o (buf_cnt)
  );

  pkt_idle_tmr #(.LIMIT(IDLE_CYC)) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (rx_vld),
    .quiet_o   (quiet)
  );

  // packet length is frozen at release; later bytes wait for the next gap
  assign start     = !drain_q && quiet && (buf_cnt != '0);
  assign m_valid_o = drain_q;
  assign m_last_o  = drain_q && (remain_q == BCW'(1));
  assign buf_pop   = drain_q && m_ready_i;
  assign busy_o    = drain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drain_q  <= 1'b0;
      remain_q <= '0;
    end else if (start) begin
      drain_q  <= 1'b1;
      remain_q <= buf_cnt;
    end else if (buf_pop) begin
      remain_q <= remain_q - 1'b1;
      if (remain_q == BCW'(1)) drain_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_err_o <= 1'b0;
      overflow_o  <= 1'b0;
    end else begin
      if (rx_ferr)              frame_err_o <= 1'b1;
      if (rx_vld && fifo_full)  overflow_o  <= 1'b1;
    end
  end

endmodule

// File: rtl/pkt_uart_gap_chk.sv
module pkt_uart_gap_chk #(
  parameter int CLK_FREQ_HZ = 50_000_000,
  parameter int IDLE_US     = 16_000
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       byte_vld_i,
  input logic [7:0] m_data_i,
  input logic       m_valid_i,
  input logic       m_last_i,
  input logic       m_ready_i,
  input logic       frame_err_i,
  input logic       overflow_i
);
  localparam int IDLE_CYC = pkt_pkg::calc_idle_cyc(CLK_FREQ_HZ, IDLE_US);

  logic [31:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              gap_q <= '0;
    else if (byte_vld_i)      gap_q <= '0;
    else if (gap_q != '1)     gap_q <= gap_q + 1'b1;
  end

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_valid_i && !m_ready_i |=> m_valid_i && $stable(m_data_i) && $stable(m_last_i));

  p_gap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(m_valid_i) |-> gap_q >= 32'(IDLE_CYC));

  p_last_valid_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_last_i |-> m_valid_i);

  p_pkt_end_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_valid_i && m_ready_i && m_last_i |=> !m_valid_i);

  p_ferr_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_i |=> frame_err_i);

  p_ovf_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_i |=> overflow_i);

endmodule

bind pkt_uart_gap pkt_uart_gap_chk #(
  .CLK_FREQ_HZ (CLK_FREQ_HZ),
  .IDLE_US     (IDLE_US)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .byte_vld_i  (rx_vld),
  .m_data_i    (m_data_o),
  .m_valid_i   (m_valid_o),
  .m_last_i    (m_last_o),
  .m_ready_i   (m_ready_i),
  .frame_err_i (frame_err_o),
  .overflow_i  (overflow_o)
);

// File: tb/sim_pkt_uart_gap.sv
`timescale 1ns/1ps
module sim_pkt_uart_gap;
  localparam int CLK_HZ   = 50_000_000;
  localparam int BAUD     = 3_125_000;
  localparam int IDLE_US  = 8;
  localparam int IDLE_CYC = 400;
  localparam int BIT      = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx = 1'b1;
  logic [7:0] m_data;
  logic       m_valid, m_last, busy, ferr, ovf;
  logic       m_ready = 1'b0;
  bit         rnd_rdy = 1'b0;
  bit         done = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  logic [8:0] got_q[$];
  logic [8:0] exp_q[$];

  always #10 clk = ~clk;

  pkt_uart_gap #(
    .CLK_FREQ_HZ (CLK_HZ),
    .BAUD        (BAUD),
    .IDLE_US     (IDLE_US)
  ) u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .rx_i        (rx),
    .m_data_o    (m_data),
    .m_valid_o   (m_valid),
    .m_last_o    (m_last),
    .m_ready_i   (m_ready),
    .busy_o      (busy),
    .frame_err_o (ferr),
    .overflow_o  (ovf)
  );

  function automatic logic [8:0] ent(logic last, logic [7:0] d);
    return {last, d};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // monitor: handshake seen at negedge completes at next posedge
  initial forever begin
    @(negedge clk);
    if (rst_n && m_valid && m_ready) got_q.push_back(ent(m_last, m_data));
  end

  initial forever begin
    @(posedge clk);
    #2;
    if (rnd_rdy) m_ready = ($urandom % 4) != 0;
  end

  initial begin
    repeat (190_000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  task automatic set_ready(logic v);
    @(posedge clk);
    #2;
    m_ready = v;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_byte(logic [7:0] b, bit good_stop);
    rx = 1'b0;
    wait_cyc(BIT);
    for (int i = 0; i < 8; i++) begin
      rx = b[i];
      wait_cyc(BIT);
    end
    rx = good_stop;
    wait_cyc(BIT);
    if (!good_stop) begin
      rx = 1'b1;
      wait_cyc(2 * BIT);
    end
  endtask

  task automatic expect_pkt(logic [7:0] d[$]);
    for (int i = 0; i < d.size(); i++) exp_q.push_back(ent(i == d.size() - 1, d[i]));
  endtask

  task automatic compare(string req);
    int n;
    n = (got_q.size() < exp_q.size()) ? got_q.size() : exp_q.size();
    for (int i = 0; i < n; i++) chk(req, 32'(got_q[i]), 32'(exp_q[i]));
    chk({req, " count"}, got_q.size(), exp_q.size());
    got_q.delete();
    exp_q.delete();
  endtask

  initial begin
    logic [7:0] pk[$];
    void'($urandom(32'd20240917));

    wait_cyc(5);
    chk("R8 valid", m_valid, 0);
    chk("R8 busy", busy, 0);
    chk("R8 ferr", ferr, 0);
    chk("R8 ovf", ovf, 0);
    rst_n = 1'b1;
    wait_cyc(5);
    chk("R8 valid after release", m_valid, 0);

    // R4 R6 R7 R9: gap timing, hold, bytes during drain
    set_ready(1'b0);
    pk = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
    foreach (pk[i]) send_byte(pk[i], 1'b1);
    expect_pkt(pk);
    wait_cyc(IDLE_CYC - 40);
    chk("R4 no early release", busy, 0);
    wait_cyc(80);
    chk("R9 busy on release", busy, 1);
    chk("R4 valid after gap", m_valid, 1);
    chk("R1 first byte", m_data, 8'h11);
    wait_cyc(20);
    chk("R7 hold valid", m_valid, 1);
    chk("R7 hold data", m_data, 8'h11);
    chk("R7 hold last", m_last, 0);
    pk = '{8'hA0, 8'hB1, 8'hC2};
    foreach (pk[i]) send_byte(pk[i], 1'b1);
    expect_pkt(pk);
    set_ready(1'b1);
    wait_cyc(20);
    chk("R6 gap between packets", busy, 0);
    wait_cyc(2 * IDLE_CYC);
    compare("R6 R5 drain split");
    chk("R9 busy idle", busy, 0);

    // R10: short low glitch
    rx = 1'b0;
    wait_cyc(4);
    rx = 1'b1;
    wait_cyc(3 * IDLE_CYC);
    chk("R10 no byte", got_q.size(), 0);
    chk("R10 no ferr", ferr, 0);
    chk("R10 not busy", busy, 0);

    // R2: bad stop bit
    chk("R2 ferr clear", ferr, 0);
    send_byte(8'hA5, 1'b1);
    send_byte(8'h3C, 1'b0);
    chk("R2 ferr set", ferr, 1);
    send_byte(8'h5A, 1'b1);
    pk = '{8'hA5, 8'h5A};
    expect_pkt(pk);
    wait_cyc(3 * IDLE_CYC);
    compare("R2 dropped byte");
    chk("R2 ferr sticky", ferr, 1);

    // R1 R4 R5: random packets, random gaps and ready
    rnd_rdy = 1'b1;
    for (int p = 0; p < 6; p++) begin
      int len;
      len = 1 + ($urandom % 12);
      pk.delete();
      for (int i = 0; i < len; i++) begin
        logic [7:0] b;
        b = 8'($urandom);
        pk.push_back(b);
        send_byte(b, 1'b1);
        wait_cyc($urandom % (8 * BIT));
      end
      expect_pkt(pk);
      wait_cyc(3 * IDLE_CYC);
    end
    compare("R1 R5 random packets");
    rnd_rdy = 1'b0;

    // R3: fill FIFO and ring, then one more
    set_ready(1'b0);
    for (int i = 0; i < 272; i++) send_byte(8'(i), 1'b1);
    chk("R3 no ovf at 272", ovf, 0);
    send_byte(8'hEE, 1'b1);
    chk("R3 ovf at 273", ovf, 1);
    pk.delete();
    for (int i = 0; i < 256; i++) pk.push_back(8'(i));
    expect_pkt(pk);
    pk.delete();
    for (int i = 256; i < 272; i++) pk.push_back(8'(i));
    expect_pkt(pk);
    wait_cyc(IDLE_CYC + 100);
    chk("R3 full packet offered", m_valid, 1);
    set_ready(1'b1);
    wait_cyc(1000);
    compare("R3 R5 overflow packets");
    chk("R3 ovf sticky", ovf, 1);

    finish_run();
  end

endmodule